// File: doc/BRIEF.md
# DMA Channel Activity Controller

This block owns the run/stop state of a single DMA channel. Software sets or clears a one-bit activity flag through a write strobe. The block then decides, cycle by cycle, when the channel moves one transfer unit. It signals each unit with a one-cycle go pulse. Address generation, the data path and the bus are left to neighbouring logic, which consume that pulse.

A channel is configured with four settings:
- where its requests come from: generated internally on every cycle, or taken from an external request line;
- whether it moves single units or whole blocks of consecutive units;
- a transfer count;
- a block length.

The count and the length are captured when the channel is started. The flag then clears by itself in any of these cases:
- the count runs out;
- an external abort arrives;
- a repeat-area overflow halts the channel;
- a non-maskable interrupt or a standby request arrives.

In block mode, a software stop that arrives in the middle of a block is held back until that block has finished. Configuration writes made while the channel runs are refused, and the refusal is recorded in a flag.

Top module: `dma_chan_activity`

## Requirements
- R1: After reset, `active_rd`, `xfer_go`, `blk_busy`, `cfg_ign` and `cnt_left` are all 0.
- R2: With `act_wr`=1 and `act_wdata`=1 while inactive and no stop event, `active_rd` reads 1 from the next cycle and `cnt_left` holds the configured count. A configured count of 0 leaves the channel inactive. Readback therefore lags the write by one cycle.
- R3: With `cfg_auto`=1 (internal requests), `xfer_go` is 1 in every cycle the channel is active and no stop event is present. No pulse occurs while inactive.
- R4: With `cfg_auto`=0 (external requests) in single mode, `xfer_go` is 1 only in active cycles where `ext_req`=1. A request seen while inactive, including in the cycle of the starting write, is dropped and never produces a later pulse.
- R5: In single mode (`cfg_block`=0), a write of 0 while active clears `active_rd` from the next cycle. A unit in that same cycle still pulses.
- R6: With `cfg_block`=1, one request (internal or external) starts a block of `cfg_len` consecutive go cycles, with a length of 0 treated as 1. `blk_busy` is 1 from the second unit to the last unit of a block. Each completed block decrements `cnt_left` by 1.
- R7: In block mode, a write of 0 while a block will continue past the current cycle leaves the channel active until the block's last unit, and clears `active_rd` the cycle after it. A write of 0 between blocks clears it the next cycle.
- R8: When the unit (single mode) or block (block mode) taken with `cnt_left`=1 completes, `active_rd` and `cnt_left` read 0 from the next cycle.
- R9: `ext_abort` or `rpt_ovf` suppresses `xfer_go` in its cycle, clears `active_rd` from the next cycle and abandons any block (`blk_busy`=0).
- R10: `nmi` or `hw_stby` suppresses `xfer_go`, clears `active_rd` from the next cycle, and overrides a simultaneous write of 1.
- R11: A `cfg_wr` while active is ignored: the next start uses the earlier settings, and `cfg_ign` reads 1 from the next cycle. An accepted `cfg_wr` while inactive clears `cfg_ign`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_wr | input | 1 | Write strobe for the activity flag |
| act_wdata | input | 1 | Value written to the activity flag |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_auto | input | 1 | 1: internal requests, 0: external requests |
| cfg_block | input | 1 | 1: block transfers, 0: single units |
| cfg_count | input | CNT_W | Number of units (single) or blocks (block) |
| cfg_len | input | LEN_W | Units per block, 0 behaves as 1 |
| ext_req | input | 1 | External transfer request |
| ext_abort | input | 1 | External abort of the channel |
| rpt_ovf | input | 1 | Repeat-area overflow halt |
| nmi | input | 1 | Non-maskable interrupt |
| hw_stby | input | 1 | Hardware standby |
| active_rd | output | 1 | Readback of the activity flag |
| xfer_go | output | 1 | One pulse per transfer unit |
| blk_busy | output | 1 | A block is partway through |
| blk_left | output | LEN_W | Units still to come in the current block |
| cnt_left | output | CNT_W | Units or blocks still to complete |
| cfg_ign | output | 1 | A configuration write was refused |

## Verification
Several rules are checked by the checker on every cycle of any stimulus:
- a go pulse never appears without an active channel;
- an external-mode single unit never fires without a request;
- every stop event and the final unit clear the flag on the next cycle;
- a single-mode stop takes effect at once;
- a deferred block-mode stop keeps the channel running;
- a refused configuration write raises its flag.

Other behaviour needs the bench's scenarios, because it depends on values carried across many cycles:
- the exact number of pulses per block;
- a zero block length acting as one;
- a dropped request never surfacing later;
- a refused count leaving the earlier count in force for the next start.

// File: rtl/dca_pkg.sv
package dca_pkg;

  // Where transfer requests come from
  typedef enum logic {
    REQ_EXT  = 1'b0,
    REQ_AUTO = 1'b1
  } req_src_e;

  // Granularity of one request
  typedef enum logic {
    XM_SINGLE = 1'b0,
    XM_BLOCK  = 1'b1
  } xfer_mode_e;

  // Channel activity state; DRAIN = stop requested, finishing the current block
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_RUN   = 2'd1,
    ACT_DRAIN = 2'd2
  } act_state_e;

endpackage

// File: rtl/dca_rst_sync.sv
module dca_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dca_cfg_regs.sv
module dca_cfg_regs
  import dca_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_auto,
  input  logic             cfg_block,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             locked,
  output req_src_e         req_src,
  output xfer_mode_e       xmode,
  output logic [CNT_W-1:0] load_count,
  output logic [LEN_W-1:0] load_len,
  output logic             cfg_ign
);

  req_src_e         src_q,   src_n;
  xfer_mode_e       mode_q,  mode_n;
  logic [CNT_W-1:0] count_q, count_n;
  logic [LEN_W-1:0] len_q,   len_n;
  logic             ign_q,   ign_n;
  logic             accept;
  logic             refuse;

  always_comb begin
    accept  = cfg_wr & ~locked;
    refuse  = cfg_wr &  locked;
    src_n   = src_q;
    mode_n  = mode_q;
    count_n = count_q;
    len_n   = len_q;
    ign_n   = ign_q;
    if (accept) begin
      src_n   = cfg_auto  ? REQ_AUTO : REQ_EXT;
      mode_n  = cfg_block ? XM_BLOCK : XM_SINGLE;
      count_n = cfg_count;
      len_n   = cfg_len;
      ign_n   = 1'b0;
    end else if (refuse) begin
      ign_n   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= REQ_EXT;
      mode_q  <= XM_SINGLE;
      count_q <= '0;
      len_q   <= '0;
      ign_q   <= 1'b0;
    end else begin
      if (accept) begin
        src_q   <= src_n;
        mode_q  <= mode_n;
        count_q <= count_n;
        len_q   <= len_n;
      end
      if (cfg_wr) ign_q <= ign_n;
    end
  end

  // A start in the same cycle as an accepted write sees the new values
  assign load_count = accept ? cfg_count : count_q;
  assign load_len   = accept ? cfg_len   : len_q;
  assign req_src    = src_q;
  assign xmode      = mode_q;
  assign cfg_ign    = ign_q;

endmodule

// File: rtl/dca_unit_ctr.sv
module dca_unit_ctr
  import dca_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             kill,
  input  logic             fire,
  input  xfer_mode_e       xmode,
  input  logic [CNT_W-1:0] load_count,
  input  logic [LEN_W-1:0] load_len,
  output logic             in_block,
  output logic [LEN_W-1:0] blk_left,
  output logic [CNT_W-1:0] cnt_left,
  output logic             last_unit,
  output logic             final_unit,
  output logic             in_block_nxt
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [LEN_W-1:0] len_run_q, len_run_n;
  logic [LEN_W-1:0] blk_q,     blk_n;
  logic [CNT_W-1:0] cnt_q,     cnt_n;
  logic             inb_q,     inb_n;
  logic [LEN_W-1:0] eff_len;
  logic             is_blk;
  logic             blk_end;

  always_comb begin
    eff_len    = (load_len == '0) ? LEN_ONE : load_len;
    is_blk     = (xmode == XM_BLOCK);
    blk_end    = inb_q ? (blk_q == LEN_ONE) : (len_run_q == LEN_ONE);
    last_unit  = fire & (~is_blk | blk_end);
    final_unit = last_unit & (cnt_q == CNT_ONE);
  end

  always_comb begin
    len_run_n = len_run_q;
    blk_n     = blk_q;
    cnt_n     = cnt_q;
    inb_n     = inb_q;
    if (kill) begin
      inb_n = 1'b0;
      blk_n = '0;
    end else if (arm) begin
      len_run_n = eff_len;
      cnt_n     = load_count;
      inb_n     = 1'b0;
      blk_n     = '0;
    end else if (fire) begin
      if (is_blk) begin
        blk_n = inb_q ? (blk_q - LEN_ONE) : (len_run_q - LEN_ONE);
        inb_n = ~blk_end;
      end
      if (last_unit) cnt_n = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_run_q <= LEN_ONE;
      blk_q     <= '0;
      cnt_q     <= '0;
      inb_q     <= 1'b0;
    end else if (kill | arm | fire) begin
      len_run_q <= len_run_n;
      blk_q     <= blk_n;
      cnt_q     <= cnt_n;
      inb_q     <= inb_n;
    end
  end

  assign in_block     = inb_q;
  assign blk_left     = blk_q;
  assign cnt_left     = cnt_q;
  assign in_block_nxt = inb_n;

endmodule

// File: rtl/dca_active_ctl.sv
module dca_active_ctl
  import dca_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_wr,
  input  logic       act_wdata,
  input  logic       kill,
  input  logic       count_nz,
  input  xfer_mode_e xmode,
  input  logic       last_unit,
  input  logic       final_unit,
  input  logic       in_block_nxt,
  output logic       active,
  output logic       arm
);

  act_state_e state_q, state_n;
  logic       stop_wr;

  always_comb begin
    arm     = act_wr & act_wdata & (state_q == ACT_IDLE) & ~kill & count_nz;
    stop_wr = act_wr & ~act_wdata;
    state_n = state_q;
    unique case (state_q)
      ACT_IDLE:  if (arm) state_n = ACT_RUN;
      ACT_RUN: begin
        if (final_unit) begin
          state_n = ACT_IDLE;
        end else if (stop_wr) begin
          state_n = ((xmode == XM_BLOCK) && in_block_nxt) ? ACT_DRAIN : ACT_IDLE;
        end
      end
      ACT_DRAIN: if (last_unit) state_n = ACT_IDLE;
      default:   state_n = ACT_IDLE;
    endcase
    if (kill) state_n = ACT_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACT_IDLE;
    else        state_q <= state_n;
  end

  assign active = (state_q != ACT_IDLE);

endmodule

// File: rtl/dma_chan_activity.sv
module dma_chan_activity
  import dca_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_wr,
  input  logic             act_wdata,
  input  logic             cfg_wr,
  input  logic             cfg_auto,
  input  logic             cfg_block,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             ext_req,
  input  logic             ext_abort,
  input  logic             rpt_ovf,
  input  logic             nmi,
  input  logic             hw_stby,
  output logic             active_rd,
  output logic             xfer_go,
  output logic             blk_busy,
  output logic [LEN_W-1:0] blk_left,
  output logic [CNT_W-1:0] cnt_left,
  output logic             cfg_ign
);

  logic             srst_n;
  req_src_e         req_src;
  xfer_mode_e       xmode;
  logic [CNT_W-1:0] load_count;
  logic [LEN_W-1:0] load_len;
  logic             active;
  logic             arm;
  logic             kill;
  logic             fire;
  logic             in_block;
  logic             last_unit;
  logic             final_unit;
  logic             in_block_nxt;
  logic             mode_auto;
  logic             mode_block;

  dca_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dca_cfg_regs #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
    .clk        (clk),
    .rst_n      (srst_n),
    .cfg_wr     (cfg_wr),
    .cfg_auto   (cfg_auto),
    .cfg_block  (cfg_block),
    .cfg_count  (cfg_count),
    .cfg_len    (cfg_len),
    .locked     (active),
    .req_src    (req_src),
    .xmode      (xmode),
    .load_count (load_count),
    .load_len   (load_len),
    .cfg_ign    (cfg_ign)
  );

  // Stop events that end the channel at once
  always_comb begin
    kill       = ext_abort | rpt_ovf | nmi | hw_stby;
    mode_auto  = (req_src == REQ_AUTO);
    mode_block = (xmode == XM_BLOCK);
    fire       = active & ~kill & (in_block | mode_auto | ext_req);
  end

  dca_unit_ctr #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctr (
    .clk          (clk),
    .rst_n        (srst_n),
    .arm          (arm),
    .kill         (kill),
    .fire         (fire),
    .xmode        (xmode),
    .load_count   (load_count),
    .load_len     (load_len),
    .in_block     (in_block),
    .blk_left     (blk_left),
    .cnt_left     (cnt_left),
    .last_unit    (last_unit),
    .final_unit   (final_unit),
    .in_block_nxt (in_block_nxt)
  );

  dca_active_ctl u_act (
    .clk          (clk),
    .rst_n        (srst_n),
    .act_wr       (act_wr),
    .act_wdata    (act_wdata),
    .kill         (kill),
    .count_nz     (load_count != '0),
    .xmode        (xmode),
    .last_unit    (last_unit),
    .final_unit   (final_unit),
    .in_block_nxt (in_block_nxt),
    .active       (active),
    .arm          (arm)
  );

  assign active_rd = active;
  assign xfer_go   = fire;
  assign blk_busy  = in_block;

endmodule

// File: rtl/dca_checker.sv
module dca_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             srst_n,
  input logic             act_wr,
  input logic             act_wdata,
  input logic             cfg_wr,
  input logic             ext_req,
  input logic             ext_abort,
  input logic             rpt_ovf,
  input logic             nmi,
  input logic             hw_stby,
  input logic             active_rd,
  input logic             xfer_go,
  input logic             blk_busy,
  input logic [CNT_W-1:0] cnt_left,
  input logic             cfg_ign,
  input logic             mode_auto,
  input logic             mode_block,
  input logic             last_unit,
  input logic             final_unit
);

  p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(active_rd) |-> $past(act_wr && act_wdata));

  p_go_needs_active_r3: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_go |-> active_rd);

  p_ext_needs_req_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (xfer_go && !mode_auto && !blk_busy) |-> ext_req);

  p_single_stop_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (active_rd && !mode_block && act_wr && !act_wdata) |=> !active_rd);

  p_block_defer_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (active_rd && mode_block && blk_busy && !last_unit && act_wr && !act_wdata &&
     !ext_abort && !rpt_ovf && !nmi && !hw_stby) |=> active_rd);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!srst_n)
    final_unit |=> (!active_rd && cnt_left == '0));

  p_abort_clears_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (ext_abort || rpt_ovf) |=> (!active_rd && !blk_busy));

  p_abort_no_go_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (ext_abort || rpt_ovf) |-> !xfer_go);

  p_nmi_stby_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (nmi || hw_stby) |=> !active_rd);

  p_refused_flag_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (active_rd && cfg_wr) |=> cfg_ign);

endmodule

bind dma_chan_activity dca_checker #(.CNT_W(CNT_W)) u_dca_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .act_wr     (act_wr),
  .act_wdata  (act_wdata),
  .cfg_wr     (cfg_wr),
  .ext_req    (ext_req),
  .ext_abort  (ext_abort),
  .rpt_ovf    (rpt_ovf),
  .nmi        (nmi),
  .hw_stby    (hw_stby),
  .active_rd  (active_rd),
  .xfer_go    (xfer_go),
  .blk_busy   (blk_busy),
  .cnt_left   (cnt_left),
  .cfg_ign    (cfg_ign),
  .mode_auto  (mode_auto),
  .mode_block (mode_block),
  .last_unit  (last_unit),
  .final_unit (final_unit)
);

// File: tb/test_dma_chan_activity.sv
module test_dma_chan_activity;

  localparam int CNT_W = 8;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             act_wr, act_wdata, cfg_wr, cfg_auto, cfg_block;
  logic [CNT_W-1:0] cfg_count;
  logic [LEN_W-1:0] cfg_len;
  logic             ext_req, ext_abort, rpt_ovf, nmi, hw_stby;
  logic             active_rd, xfer_go, blk_busy, cfg_ign;
  logic [LEN_W-1:0] blk_left;
  logic [CNT_W-1:0] cnt_left;

  // staged inputs, applied at the next falling edge
  logic             n_act_wr, n_act_wdata, n_cfg_wr, n_cfg_auto, n_cfg_block;
  logic [CNT_W-1:0] n_cfg_count;
  logic [LEN_W-1:0] n_cfg_len;
  logic             n_ext_req, n_ext_abort, n_rpt_ovf, n_nmi, n_hw_stby;

  dma_chan_activity #(.CNT_W(CNT_W), .LEN_W(LEN_W)) i_dma_chan_activity (
    .clk(clk), .rst_n(rst_n), .act_wr(act_wr), .act_wdata(act_wdata),
    .cfg_wr(cfg_wr), .cfg_auto(cfg_auto), .cfg_block(cfg_block),
    .cfg_count(cfg_count), .cfg_len(cfg_len), .ext_req(ext_req),
    .ext_abort(ext_abort), .rpt_ovf(rpt_ovf), .nmi(nmi), .hw_stby(hw_stby),
    .active_rd(active_rd), .xfer_go(xfer_go), .blk_busy(blk_busy),
    .blk_left(blk_left), .cnt_left(cnt_left), .cfg_ign(cfg_ign)
  );

  typedef struct {
    int    ea;
    int    eg;
    int    ec;
    int    eb;
    int    ei;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  task automatic idle_stage();
    n_act_wr = 0; n_act_wdata = 0; n_cfg_wr = 0;
    n_ext_req = 0; n_ext_abort = 0; n_rpt_ovf = 0; n_nmi = 0; n_hw_stby = 0;
  endtask

  // driver: apply staged inputs for one cycle and queue what the outputs must be
  task automatic cyc(input int ea, input int eg, input int ec, input int eb,
                     input int ei, input string tag);
    exp_t e;
    @(negedge clk);
    act_wr = n_act_wr; act_wdata = n_act_wdata; cfg_wr = n_cfg_wr;
    cfg_auto = n_cfg_auto; cfg_block = n_cfg_block;
    cfg_count = n_cfg_count; cfg_len = n_cfg_len;
    ext_req = n_ext_req; ext_abort = n_ext_abort; rpt_ovf = n_rpt_ovf;
    nmi = n_nmi; hw_stby = n_hw_stby;
    e.ea = ea; e.eg = eg; e.ec = ec; e.eb = eb; e.ei = ei; e.tag = tag;
    sb_q.push_back(e);
    idle_stage();
  endtask

  task automatic configure(input bit au, input bit bl, input int cnt,
                           input int len, input string tag);
    n_cfg_wr = 1; n_cfg_auto = au; n_cfg_block = bl;
    n_cfg_count = CNT_W'(cnt); n_cfg_len = LEN_W'(len);
    cyc(0, 0, -1, -1, -1, tag);
  endtask

  task automatic start(input string tag);
    n_act_wr = 1; n_act_wdata = 1;
    cyc(0, 0, -1, -1, -1, tag);
  endtask

  task automatic cmp(input int act, input int exp, input string what,
                     input string tag);
    if (exp >= 0) begin
      checks++;
      if (act != exp) begin
        failures++;
        $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
    end
  endtask

  // monitor: pop one expectation per cycle and compare away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(int'(active_rd), e.ea, "active_rd", e.tag);
        cmp(int'(xfer_go),   e.eg, "xfer_go",   e.tag);
        cmp(int'(cnt_left),  e.ec, "cnt_left",  e.tag);
        cmp(int'(blk_busy),  e.eb, "blk_busy",  e.tag);
        cmp(int'(cfg_ign),   e.ei, "cfg_ign",   e.tag);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    n_cfg_auto = 0; n_cfg_block = 0; n_cfg_count = '0; n_cfg_len = '0;
    idle_stage();
    act_wr = 0; act_wdata = 0; cfg_wr = 0; cfg_auto = 0; cfg_block = 0;
    cfg_count = '0; cfg_len = '0; ext_req = 0; ext_abort = 0; rpt_ovf = 0;
    nmi = 0; hw_stby = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cyc(0, 0, 0, 0, 0, "R1");

    // R3 R8 R2: single, internal requests, count 3
    configure(1, 0, 3, 0, "R3 cfg");
    start("R2 start");
    cyc(1, 1, 3, 0, -1, "R2 R3 first unit");
    cyc(1, 1, 2, 0, -1, "R3 second unit");
    cyc(1, 1, 1, 0, -1, "R8 last unit");
    cyc(0, 0, 0, 0, -1, "R8 exhausted");

    // R2 zero count does not start
    configure(1, 0, 0, 0, "R2 cfg zero");
    start("R2 start zero");
    cyc(0, 0, 0, 0, -1, "R2 zero count stays off");

    // R4: single, external requests, count 2
    configure(0, 0, 2, 0, "R4 cfg");
    n_ext_req = 1; cyc(0, 0, -1, -1, -1, "R4 req while off");
    n_act_wr = 1; n_act_wdata = 1; n_ext_req = 1;
    cyc(0, 0, -1, -1, -1, "R4 req in start cycle");
    cyc(1, 0, 2, 0, -1, "R4 dropped request no pulse");
    n_ext_req = 1; cyc(1, 1, 2, 0, -1, "R4 request pulses");
    cyc(1, 0, 1, 0, -1, "R4 no request no pulse");
    n_ext_req = 1; cyc(1, 1, 1, 0, -1, "R4 R8 final request");
    cyc(0, 0, 0, 0, -1, "R8 ext exhausted");
    n_ext_req = 1; cyc(0, 0, 0, 0, -1, "R4 req after done");

    // R5: single stop is immediate
    configure(1, 0, 10, 0, "R5 cfg");
    start("R5 start");
    cyc(1, 1, 10, 0, -1, "R5 running");
    n_act_wr = 1; n_act_wdata = 0;
    cyc(1, 1, 9, 0, -1, "R5 stop cycle still pulses");
    cyc(0, 0, 8, 0, -1, "R5 stopped");

    // R6 R7: block, external requests, length 3, three blocks
    configure(0, 1, 3, 3, "R6 cfg");
    start("R6 start");
    cyc(1, 0, 3, 0, -1, "R6 waiting request");
    n_ext_req = 1; cyc(1, 1, 3, 0, -1, "R6 block unit 1");
    cyc(1, 1, 3, 1, -1, "R6 block unit 2 no request");
    cyc(1, 1, 3, 1, -1, "R6 block unit 3");
    cyc(1, 0, 2, 0, -1, "R6 block done count down");
    n_ext_req = 1; cyc(1, 1, 2, 0, -1, "R7 second block unit 1");
    n_act_wr = 1; n_act_wdata = 0;
    cyc(1, 1, 2, 1, -1, "R7 stop during block");
    cyc(1, 1, 2, 1, -1, "R7 deferred last unit");
    cyc(0, 0, 1, 0, -1, "R7 cleared after block");

    // R7: stop between blocks is immediate
    configure(0, 1, 5, 2, "R7 cfg gap");
    start("R7 start gap");
    cyc(1, 0, 5, 0, -1, "R7 idle between blocks");
    n_act_wr = 1; n_act_wdata = 0;
    cyc(1, 0, 5, 0, -1, "R7 stop between blocks");
    cyc(0, 0, 5, 0, -1, "R7 stopped between blocks");

    // R6: length 0 acts as 1, internal requests
    configure(1, 1, 2, 0, "R6 cfg len0");
    start("R6 start len0");
    cyc(1, 1, 2, 0, -1, "R6 len0 block one unit");
    cyc(1, 1, 1, 0, -1, "R6 R8 len0 second block");
    cyc(0, 0, 0, 0, -1, "R8 len0 done");

    // R9: abort mid block
    configure(1, 1, 2, 4, "R9 cfg");
    start("R9 start");
    cyc(1, 1, 2, 0, -1, "R9 unit 1");
    cyc(1, 1, 2, 1, -1, "R9 unit 2");
    n_ext_abort = 1; cyc(1, 0, 2, 1, -1, "R9 abort suppresses go");
    cyc(0, 0, 2, 0, -1, "R9 aborted block dropped");

    // R9: repeat-area overflow
    configure(1, 0, 5, 0, "R9 cfg ovf");
    start("R9 start ovf");
    cyc(1, 1, 5, 0, -1, "R9 ovf running");
    n_rpt_ovf = 1; cyc(1, 0, 4, 0, -1, "R9 ovf suppresses go");
    cyc(0, 0, 4, 0, -1, "R9 ovf cleared");

    // R10: nmi beats a start, standby stops a run
    configure(1, 0, 4, 0, "R10 cfg");
    n_act_wr = 1; n_act_wdata = 1; n_nmi = 1;
    cyc(0, 0, -1, 0, -1, "R10 nmi with start");
    cyc(0, 0, -1, 0, -1, "R10 start overridden");
    start("R10 start");
    cyc(1, 1, 4, 0, -1, "R10 running");
    n_hw_stby = 1; cyc(1, 0, 3, 0, -1, "R10 standby suppresses go");
    cyc(0, 0, 3, 0, -1, "R10 standby cleared");

    // R11: refused configuration while running
    configure(1, 0, 2, 0, "R11 cfg");
    start("R11 start");
    n_cfg_wr = 1; n_cfg_auto = 1; n_cfg_block = 0; n_cfg_count = 7;
    cyc(1, 1, 2, 0, 0, "R11 write while active");
    cyc(1, 1, 1, 0, 1, "R11 flag set");
    cyc(0, 0, 0, 0, 1, "R11 done");
    start("R11 restart");
    cyc(1, 1, 2, 0, 1, "R11 old count kept");
    cyc(1, 1, 1, 0, 1, "R11 old count runs");
    n_cfg_wr = 1; n_cfg_auto = 1; n_cfg_block = 0; n_cfg_count = 2;
    cyc(0, 0, 0, 0, 1, "R11 accepted write");
    cyc(0, 0, 0, 0, 0, "R11 flag cleared");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule